// File: doc/BRIEF.md
# Coherent Navigation Bit Demodulator

This block turns a stream of 1 ms complex correlation results into navigation data bits. Each incoming sample carries a signed in-phase value, a signed quadrature value and the current carrier phase estimate as an unsigned fraction of a cycle. The block de-rotates the pair through that phase, using sine and cosine values taken from a quarter-wave lookup table. It then sums the de-rotated in-phase term over one bit period of twenty samples and hands out the sign of the sum as a hard bit decision.

An internal 1 ms epoch counter (0 to 19) tags every accepted sample and marks where a bit starts and ends. The bit-boundary search and the tracking loops run elsewhere. When they find that the counter is out of step with the true bit edge, they issue a slew request with a new epoch value. The next accepted sample takes that epoch, and the partial bit then under integration is dropped. This lets the surrounding logic keep moving the counter for as long as it tracks the edge position.

Samples enter on a valid/ready stream, and bits leave on a valid/ready stream. A pending bit that has not been taken blocks all input, so `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. `in_ready` never depends on `in_valid`. A producer may hold `in_valid` high for as long as it likes. A bit, once offered, stays offered with the same value until it is taken. The de-rotated values come out on a plain monitor port with a one-cycle strobe. The slew controls are plain pins.

Top module: `nav_bit_demod`

## Requirements
- R1: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. In the cycle after acceptance, `rot_valid` is high for exactly one cycle. At that point `rot_i` equals floor(I·C/512) + floor(Q·S/512) and `rot_q` equals floor(Q·C/512) − floor(I·S/512). Here S and C are the table sine and cosine of the sample's phase, and floor means an arithmetic right shift by 9.
- R2: For an 8-bit phase p, S is round(511·sin(2π(p+0.5)/256)), with ties away from zero, and C is S at phase (p+64) mod 256. Both are signed 10-bit values folded from a 64-entry quarter-wave table.
- R3: The bit accumulator holds the sum of twenty full-scale de-rotated values without wrapping. With I = Q = −32768 at phase 32 the bit is 0, and with I = Q = 32767 at phase 32 the bit is 1.
- R4: After the sample with epoch 19 closes a bit, `out_valid` rises in the following cycle. `out_bit` is 1 when the sum of the bit's twenty `rot_i` values is zero or positive, and 0 when the sum is negative. With `out_ready` high, `out_valid` lasts one cycle.
- R5: `epoch_now` is the epoch that the next accepted sample will take. It is 0 after reset. It steps by one on each accepted sample, wraps from 19 to 0, and does not change while no sample is accepted.
- R6: A sample with epoch 0 restarts the sum. No bit is produced on any accepted sample other than one with epoch 19.
- R7: A `slew_req` pulse with `slew_epoch` ≤ 19 makes the next accepted sample take epoch `slew_epoch` in place of the counter value. Until that sample arrives, `epoch_now` does not change. After it, `epoch_now` reads `slew_epoch`+1, wrapping 19 to 0.
- R8: A slew to a non-zero epoch discards the partial bit, so no bit comes out at the next epoch 19. A slew to epoch 0 starts a fresh bit that excludes every earlier sample. A `slew_req` with `slew_epoch` ≥ 20 is ignored.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_bit` holds its value and `in_ready` is low. Otherwise `in_ready` is high.
- R10: After reset, `out_valid` and `rot_valid` are 0, `in_ready` is 1 and `epoch_now` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be accepted |
| in_i | input | 16 | Signed in-phase correlation |
| in_q | input | 16 | Signed quadrature correlation |
| in_phase | input | 8 | Carrier phase, unsigned fraction of a cycle |
| slew_req | input | 1 | Request to re-tag the next sample's epoch |
| slew_epoch | input | 5 | Epoch to apply on a slew |
| epoch_now | output | 5 | Epoch the next accepted sample takes |
| rot_valid | output | 1 | De-rotated values updated |
| rot_i | output | 18 | Signed de-rotated in-phase value |
| rot_q | output | 18 | Signed de-rotated quadrature value |
| out_valid | output | 1 | Bit decision offered |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | Hard bit decision |

## Verification
The de-rotated values, the epoch step and a bit closed by an epoch-19 sample are all due at the first rising edge after the accepting edge. `in_ready` follows `out_valid` and `out_ready` within the same cycle. The bench drives every input on the falling edge and reads outputs 1 ns after the rising edge that should update them. It reads the epoch-18 and epoch-19 results at consecutive edges, and reads the strobe drop at the edge after that. During back-pressure the bench waits several whole cycles before releasing `out_ready`, and it checks `in_ready` both before and after the release in the same cycle.

// File: rtl/nav_demod_pkg.sv
package nav_demod_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Quarter-wave sine sample k of a table with 2**qbits entries per quadrant,
  // taken half a step off the axis so the four quadrants fold symmetrically.
  function automatic int quarter_sin(input int k, input int amp, input int qbits);
    real ang;
    ang = TWO_PI * (real'(k) + 0.5) / real'(4 * (1 << qbits));
    return int'(real'(amp) * $sin(ang));
  endfunction

endpackage

// File: rtl/nav_trig_lut.sv
module nav_trig_lut #(
  parameter int PW = 8,
  parameter int TW = 10
) (
  input  logic [PW-1:0]        phase,
  output logic signed [TW-1:0] sin_o,
  output logic signed [TW-1:0] cos_o
);
  localparam int QB    = PW - 2;
  localparam int DEPTH = 1 << QB;
  localparam int AMP   = (1 << (TW - 1)) - 1;

  logic signed [TW-1:0] tab [DEPTH];
  logic signed [TW-1:0] val [2];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int V = nav_demod_pkg::quarter_sin(k, AMP, QB);
    assign tab[k] = TW'(V);
  end

  // Path 0 reads sine at the phase; path 1 reads sine a quarter cycle ahead.
  for (genvar c = 0; c < 2; c++) begin : g_fold
    localparam logic [PW-1:0] OFS = PW'(c * DEPTH);
    logic [PW-1:0]        ph;
    logic [1:0]           quad;
    logic [QB-1:0]        idx;
    logic signed [TW-1:0] mag;
    assign ph   = phase + OFS;
    assign quad = ph[PW-1:PW-2];
    assign idx  = quad[0] ? ~ph[QB-1:0] : ph[QB-1:0];
    assign mag  = tab[idx];
    assign val[c] = quad[1] ? -mag : mag;
  end

  assign sin_o = val[0];
  assign cos_o = val[1];
endmodule

// File: rtl/nav_rotator.sv
module nav_rotator #(
  parameter int IW    = 16,
  parameter int TW    = 10,
  parameter int SHIFT = 9,
  localparam int RW   = IW + TW + 1 - SHIFT
) (
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  input  logic signed [TW-1:0] sin_v,
  input  logic signed [TW-1:0] cos_v,
  output logic signed [RW-1:0] rot_i,
  output logic signed [RW-1:0] rot_q
);
  localparam int PRW = IW + TW;
  localparam int SW  = PRW - SHIFT;

  logic signed [PRW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [SW-1:0]  s_ic, s_qs, s_qc, s_is;

  assign p_ic = in_i * cos_v;
  assign p_qs = in_q * sin_v;
  assign p_qc = in_q * cos_v;
  assign p_is = in_i * sin_v;

  assign s_ic = SW'(p_ic >>> SHIFT);
  assign s_qs = SW'(p_qs >>> SHIFT);
  assign s_qc = SW'(p_qc >>> SHIFT);
  assign s_is = SW'(p_is >>> SHIFT);

  assign rot_i = RW'(s_ic) + RW'(s_qs);
  assign rot_q = RW'(s_qc) - RW'(s_is);
endmodule

// File: rtl/nav_bit_integrator.sv
module nav_bit_integrator #(
  parameter int RW      = 18,
  parameter int BIT_LEN = 20,
  localparam int EW     = $clog2(BIT_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic signed [RW-1:0] rot_i,
  input  logic                 slew_req,
  input  logic [EW-1:0]        slew_epoch,
  input  logic                 out_ready,
  output logic [EW-1:0]        epoch_now,
  output logic                 out_valid,
  output logic                 out_bit
);
  localparam int AW = RW + $clog2(BIT_LEN);
  localparam logic [EW-1:0] LAST = EW'(BIT_LEN - 1);

  logic [EW-1:0]        epoch_q, slew_val, cur_ep;
  logic                 slew_pend, full_q, full_nxt, restart, bit_done;
  logic signed [AW-1:0] acc_q, acc_nxt;

  always_comb begin
    cur_ep   = slew_pend ? slew_val : epoch_q;
    restart  = (cur_ep == '0) || slew_pend;
    acc_nxt  = restart ? AW'(rot_i) : acc_q + AW'(rot_i);
    if (cur_ep == '0)   full_nxt = 1'b1;
    else if (slew_pend) full_nxt = 1'b0;
    else                full_nxt = full_q;
    bit_done = accept && (cur_ep == LAST) && full_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epoch_q   <= '0;
      acc_q     <= '0;
      full_q    <= 1'b0;
      slew_pend <= 1'b0;
      slew_val  <= '0;
    end else begin
      if (accept) begin
        acc_q     <= acc_nxt;
        full_q    <= full_nxt;
        epoch_q   <= (cur_ep == LAST) ? '0 : cur_ep + EW'(1);
        slew_pend <= 1'b0;
      end
      if (slew_req && (slew_epoch <= LAST)) begin
        slew_pend <= 1'b1;
        slew_val  <= slew_epoch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (bit_done) begin
      out_valid <= 1'b1;
      out_bit   <= ~acc_nxt[AW-1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign epoch_now = epoch_q;
endmodule

// File: rtl/nav_bit_demod.sv
module nav_bit_demod #(
  parameter int IW      = 16,
  parameter int PW      = 8,
  parameter int TW      = 10,
  parameter int SHIFT   = 9,
  parameter int BIT_LEN = 20,
  localparam int RW     = IW + TW + 1 - SHIFT,
  localparam int EW     = $clog2(BIT_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  input  logic [PW-1:0]        in_phase,
  input  logic                 slew_req,
  input  logic [EW-1:0]        slew_epoch,
  output logic [EW-1:0]        epoch_now,
  output logic                 rot_valid,
  output logic signed [RW-1:0] rot_i,
  output logic signed [RW-1:0] rot_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit
);
  logic signed [TW-1:0] sin_v, cos_v;
  logic signed [RW-1:0] ri_c, rq_c;
  logic                 accept;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  nav_trig_lut #(.PW(PW), .TW(TW)) lut_i (
    .phase (in_phase),
    .sin_o (sin_v),
    .cos_o (cos_v)
  );

  nav_rotator #(.IW(IW), .TW(TW), .SHIFT(SHIFT)) rot_i_u (
    .in_i  (in_i),
    .in_q  (in_q),
    .sin_v (sin_v),
    .cos_v (cos_v),
    .rot_i (ri_c),
    .rot_q (rq_c)
  );

  nav_bit_integrator #(.RW(RW), .BIT_LEN(BIT_LEN)) integ_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rot_i      (ri_c),
    .slew_req   (slew_req),
    .slew_epoch (slew_epoch),
    .out_ready  (out_ready),
    .epoch_now  (epoch_now),
    .out_valid  (out_valid),
    .out_bit    (out_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_valid <= 1'b0;
      rot_i     <= '0;
      rot_q     <= '0;
    end else begin
      rot_valid <= accept;
      if (accept) begin
        rot_i <= ri_c;
        rot_q <= rq_c;
      end
    end
  end
endmodule

// File: rtl/nav_bit_demod_chk.sv
module nav_bit_demod_chk #(
  parameter int BIT_LEN = 20,
  localparam int EW     = $clog2(BIT_LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [EW-1:0] epoch_now,
  input logic          rot_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_bit
);
  localparam logic [EW-1:0] LAST = EW'(BIT_LEN - 1);

  logic acc_ok;
  assign acc_ok = in_valid & in_ready;

  AST_EPOCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_now <= LAST); // R5
  AST_EPOCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> $stable(epoch_now)); // R5
  AST_ROT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> rot_valid); // R1
  AST_ROT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> !rot_valid); // R1
  AST_BIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ok && epoch_now == LAST) |=>
      !(out_valid && (!$past(out_valid) || $past(out_ready)))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R9
  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
endmodule

bind nav_bit_demod nav_bit_demod_chk #(.BIT_LEN(BIT_LEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .epoch_now (epoch_now),
  .rot_valid (rot_valid),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit)
);

// File: tb/nav_bit_demod_tb_top.sv
`timescale 1ns/1ps
module nav_bit_demod_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, slew_req = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [7:0] in_phase = '0;
  logic [4:0] slew_epoch = '0;
  logic in_ready, rot_valid, out_valid, out_bit;
  logic [4:0] epoch_now;
  logic signed [17:0] rot_i, rot_q;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nav_bit_demod dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .in_phase(in_phase), .slew_req(slew_req),
    .slew_epoch(slew_epoch), .epoch_now(epoch_now), .rot_valid(rot_valid),
    .rot_i(rot_i), .rot_q(rot_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sin(input int p);
    return int'(511.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 256.0));
  endfunction
  function automatic int ref_cos(input int p);
    return ref_sin((p + 64) % 256);
  endfunction
  function automatic int ref_ri(input int i, input int q, input int p);
    return ((i * ref_cos(p)) >>> 9) + ((q * ref_sin(p)) >>> 9);
  endfunction
  function automatic int ref_rq(input int i, input int q, input int p);
    return ((q * ref_cos(p)) >>> 9) - ((i * ref_sin(p)) >>> 9);
  endfunction

  task automatic send(input int i, input int q, input int p);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    in_phase = 8'(p);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic slew(input int v);
    @(negedge clk);
    slew_req = 1'b1;
    slew_epoch = 5'(v);
    @(negedge clk);
    slew_req = 1'b0;
  endtask

  // Full bit of identical samples from epoch 0; checks silence then the bit.
  task automatic run_bit(input string tag, input int i, input int q, input int p);
    longint sum = 0;
    for (int n = 0; n < 20; n++) begin
      send(i, q, p);
      sum += ref_ri(i, q, p);
      if (n == 18) check({tag, " R6 no bit before epoch 19"}, out_valid, 0);
    end
    check({tag, " R4 valid after epoch 19"}, out_valid, 1);
    check({tag, " R4 bit sign"}, out_bit, (sum >= 0) ? 1 : 0);
    @(posedge clk); #1;
    check({tag, " R4 one-cycle strobe"}, out_valid, 0);
  endtask

  task automatic t_reset();
    check("R10 out_valid", out_valid, 0);
    check("R10 rot_valid", rot_valid, 0);
    check("R10 in_ready", in_ready, 1);
    check("R10 epoch", epoch_now, 0);
  endtask

  task automatic t_rotate();
    int ph[7] = '{0, 37, 64, 100, 128, 200, 255};
    int iv[7] = '{1000, -2000, 30000, -32768, 12345, 500, -700};
    int qv[7] = '{0, 1500, -30000, 32767, -4321, -9000, 800};
    for (int n = 0; n < 7; n++) begin
      send(iv[n], qv[n], ph[n]);
      check("R1 rot_valid", rot_valid, 1);
      check("R1 R2 rot_i", rot_i, ref_ri(iv[n], qv[n], ph[n]));
      check("R1 R2 rot_q", rot_q, ref_rq(iv[n], qv[n], ph[n]));
    end
    @(posedge clk); #1;
    check("R1 rot_valid drops", rot_valid, 0);
    check("R5 epoch after 7", epoch_now, 7);
    @(posedge clk); #1;
    check("R5 epoch idle", epoch_now, 7);
  endtask

  task automatic t_slew();
    slew(0);
    check("R7 epoch waits for sample", epoch_now, 7);
    run_bit("slew0 fresh", -3000, 200, 128);
    for (int n = 0; n < 5; n++) send(100, 0, 0);
    slew(7);
    check("R7 pending keeps epoch", epoch_now, 5);
    send(100, 0, 0);
    check("R7 epoch after slew", epoch_now, 8);
    for (int n = 0; n < 12; n++) begin
      send(100, 0, 0);
      check("R8 no bit after nonzero slew", out_valid, 0);
    end
    check("R5 wrap to 0", epoch_now, 0);
    for (int n = 0; n < 3; n++) send(-30000, 0, 0);
    slew(0);
    run_bit("R8 partial discarded", 50, 0, 0);
    send(10, 0, 0);
    slew(25);
    send(10, 0, 0);
    check("R8 out-of-range slew ignored", epoch_now, 2);
    slew(0);
  endtask

  task automatic t_backpressure();
    bit held;
    out_ready = 1'b0;
    for (int n = 0; n < 20; n++) send(-800, 300, 10);
    check("R9 valid", out_valid, 1);
    check("R9 in_ready low", in_ready, 0);
    held = out_bit;
    repeat (3) @(posedge clk);
    #1;
    check("R9 valid held", out_valid, 1);
    check("R9 bit held", out_bit, held);
    check("R9 in_ready still low", in_ready, 0);
    check("R4 bit under stall", out_bit, (ref_ri(-800, 300, 10) >= 0) ? 1 : 0);
    @(negedge clk);
    out_ready = 1'b1;
    #0.5;
    check("R9 in_ready follows out_ready", in_ready, 1);
    @(posedge clk); #1;
    check("R9 valid clears after take", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_rotate();
    t_slew();
    run_bit("R4 positive", 1000, 0, 0);
    run_bit("R4 negative", 1000, 0, 128);
    run_bit("R4 zero sum", 0, 0, 77);
    run_bit("R4 quadrature path", 0, 800, 64);
    run_bit("R3 full-scale negative", -32768, -32768, 32);
    run_bit("R3 full-scale positive", 32767, 32767, 32);
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule